// File: doc/BRIEF.md
# Timekeeper Status Flags and Interrupt Controller

This block holds the status flags and interrupt logic that sit beside a free-running binary seconds counter. Software reaches it over a small parallel register port with an address, write data, a registered read data path, and separate read and write strobes. The block watches an oscillator-running input, a set of periodic rate taps and the current seconds count. From these it keeps four status flags: oscillator-stopped, update-in-progress, periodic and alarm. It drives an active-low interrupt output that is gated by two enable bits.

Counter updates are staged by a three-state sequencer. A step request moves it from `UPD_IDLE` to `UPD_WARN`, which raises the update-in-progress flag. After a fixed number of cycles (`WARN_DONE`) it moves to `UPD_APPLY`, which drops the flag and pulses `upd_fire` to the external counter for one cycle. From `UPD_APPLY` it goes back to `UPD_WARN` if another request is pending (`APPLY_AGAIN`), or to `UPD_IDLE` if none is (`APPLY_DONE`). The warning length is derived from the clock frequency so that it covers 60 µs. Software that reads the flag as 0 therefore has at least that long before the counter changes.

Register map, with a 4-bit address:

| Address | Contents |
|---|---|
| 0 | Status |
| 1 | Control: bit 0 = alarm enable, bit 1 = periodic enable |
| 2 | Rate: bits 2:0 = tap select |
| 4 to 7 | Alarm compare value, least significant byte at address 4 |

Top module: `tk_status_irq`

## Requirements
- R1: After reset, status reads 0x80, control and rate read 0, and `irq_n` is 1.
- R2: The oscillator-stopped flag (status bit 7) becomes 1 in any cycle where `osc_run` is 0. It stays 1 after `osc_run` returns to 1.
- R3: A write to address 0 clears every set flag among bits 7, 1 and 0. If a set event for a flag lands on the same cycle as the write, that flag stays 1.
- R4: Status bits 5 to 2 always read 0. A status write never changes bit 6 (update-in-progress).
- R5: When the rate field n is between 1 and 7, each rising edge of `rate_taps[n-1]` sets the periodic flag (status bit 1). When n is 0, no tap sets the flag.
- R6: While the periodic flag is already 1, further rate edges leave it at 1 and cause no other change.
- R7: The alarm flag (status bit 0) is set on the cycle where `sec_count` becomes equal to the alarm value. A clear while the two stay equal is not undone.
- R8: `irq_n` is 0 exactly when (periodic flag AND control bit 1) OR (alarm flag AND control bit 0). It returns to 1 when the flags are cleared or the enables are turned off.
- R9: A `step_req` pulse in idle sets status bit 6 for exactly UIP_CYC cycles. `upd_fire` then pulses for one cycle, in the cycle where bit 6 falls.
- R10: A `step_req` that arrives while an update is staged is held, then served right after the current update. The second `upd_fire` follows the first by UIP_CYC+1 cycles.
- R11: `rdata` takes the addressed register one cycle after `rd_en`. Addresses 3 and 8 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Registered read data |
| osc_run | input | 1 | High while the oscillator runs |
| step_req | input | 1 | Request for a counter update |
| rate_taps | input | 7 | Periodic rate taps |
| sec_count | input | 32 | Current seconds count |
| upd_fire | output | 1 | One-cycle counter update strobe |
| irq_n | output | 1 | Active-low interrupt |

## Verification
On every cycle, the checker proves four things. Flag setting and write-clear follow their events. The interrupt output never asserts without an enabled flag. Reserved status bits read 0. Each update strobe coincides with the falling edge of update-in-progress after a full warning window, which is counted in the checker. The bench scenarios are needed for the behaviour that depends on history and on the register port:

- tap selection, including select 0;
- alarm edge detection while the count stays equal;
- the event-wins collision with a clear;
- queuing of a second step request;
- the read latency and unmapped addresses.

// File: rtl/tk_pkg.sv
package tk_pkg;
    typedef enum logic [1:0] {
        UPD_IDLE  = 2'd0,
        UPD_WARN  = 2'd1,
        UPD_APPLY = 2'd2
    } upd_state_t;

    localparam int ADDR_W    = 4;
    localparam int DATA_W    = 8;
    localparam int A_STATUS  = 0;
    localparam int A_CTRL    = 1;
    localparam int A_RATE    = 2;
    localparam int A_ALM     = 4;

    localparam int ST_OSF = 7;
    localparam int ST_UIP = 6;
    localparam int ST_PF  = 1;
    localparam int ST_AF  = 0;
endpackage

// File: rtl/tk_upd_seq.sv
module tk_upd_seq
    import tk_pkg::*;
#(
    parameter int UIP_CYC = 12000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic step_req,
    output logic uip,
    output logic upd_fire
);
    localparam int CNT_W = $clog2(UIP_CYC + 1);

    upd_state_t state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic pend_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            UPD_IDLE:  if (step_req) state_d = UPD_WARN;
            UPD_WARN:  if (cnt_q == CNT_W'(UIP_CYC - 1)) state_d = UPD_APPLY;
            UPD_APPLY: state_d = (pend_q || step_req) ? UPD_WARN : UPD_IDLE;
            default:   state_d = UPD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= UPD_IDLE;
            cnt_q   <= '0;
            pend_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            cnt_q   <= (state_q == UPD_WARN && state_d == UPD_WARN) ? cnt_q + 1'b1 : '0;
            if (state_q == UPD_APPLY)
                pend_q <= 1'b0;
            else if (state_q == UPD_WARN && step_req)
                pend_q <= 1'b1;
        end
    end

    always_comb begin
        uip      = 1'b0;
        upd_fire = 1'b0;
        unique case (state_q)
            UPD_IDLE:  ;
            UPD_WARN:  uip = 1'b1;
            UPD_APPLY: upd_fire = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/tk_rate_pick.sv
module tk_rate_pick #(
    parameter int NUM_TAPS = 7,
    parameter int SEL_W    = $clog2(NUM_TAPS + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_TAPS-1:0] taps,
    input  logic [SEL_W-1:0]    sel,
    output logic                evt
);
    logic [NUM_TAPS-1:0] taps_q;
    logic [NUM_TAPS-1:0] rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) taps_q <= '0;
        else        taps_q <= taps;
    end

    assign rise = taps & ~taps_q;

    always_comb begin
        evt = 1'b0;
        for (int i = 0; i < NUM_TAPS; i++)
            if (int'(sel) == i + 1) evt = rise[i];
    end
endmodule

// File: rtl/tk_flag_cell.sv
module tk_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag <= RST_VAL;
        else        flag <= (flag & ~clr) | set_evt;
    end
endmodule

// File: rtl/tk_status_irq.sv
module tk_status_irq
    import tk_pkg::*;
#(
    parameter int CLK_KHZ  = 200000,
    parameter int SAFE_US  = 60,
    parameter int NUM_TAPS = 7,
    parameter int SEC_W    = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                wr_en,
    input  logic                rd_en,
    output logic [DATA_W-1:0]   rdata,
    input  logic                osc_run,
    input  logic                step_req,
    input  logic [NUM_TAPS-1:0] rate_taps,
    input  logic [SEC_W-1:0]    sec_count,
    output logic                upd_fire,
    output logic                irq_n
);
    localparam int UIP_CYC   = (CLK_KHZ * SAFE_US) / 1000;
    localparam int SEL_W     = $clog2(NUM_TAPS + 1);
    localparam int ALM_BYTES = SEC_W / 8;

    logic status_wr;
    logic osf_q, pf_q, af_q, uip;
    logic per_evt, alm_evt, match, match_q;
    logic aie_q, pie_q;
    logic [SEL_W-1:0] sel_q;
    logic [SEC_W-1:0] alarm_q;
    logic [DATA_W-1:0] rd_mux;

    assign status_wr = wr_en && (addr == ADDR_W'(A_STATUS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            aie_q <= 1'b0;
            pie_q <= 1'b0;
            sel_q <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_W'(A_CTRL)) begin
                aie_q <= wdata[0];
                pie_q <= wdata[1];
            end
            if (addr == ADDR_W'(A_RATE)) sel_q <= wdata[SEL_W-1:0];
        end
    end

    for (genvar b = 0; b < ALM_BYTES; b++) begin : g_alm
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                alarm_q[b*8 +: 8] <= '0;
            else if (wr_en && addr == ADDR_W'(A_ALM + b))
                alarm_q[b*8 +: 8] <= wdata;
        end
    end

    assign match = (sec_count == alarm_q);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= 1'b1;
        else        match_q <= match;
    end
    assign alm_evt = match & ~match_q;

    tk_upd_seq #(.UIP_CYC(UIP_CYC)) u_seq (
        .clk(clk), .rst_n(rst_n), .step_req(step_req),
        .uip(uip), .upd_fire(upd_fire)
    );

    tk_rate_pick #(.NUM_TAPS(NUM_TAPS), .SEL_W(SEL_W)) u_rate (
        .clk(clk), .rst_n(rst_n), .taps(rate_taps), .sel(sel_q), .evt(per_evt)
    );

    tk_flag_cell #(.RST_VAL(1'b1)) u_osf (
        .clk(clk), .rst_n(rst_n), .set_evt(~osc_run), .clr(status_wr), .flag(osf_q)
    );
    tk_flag_cell #(.RST_VAL(1'b0)) u_pf (
        .clk(clk), .rst_n(rst_n), .set_evt(per_evt), .clr(status_wr), .flag(pf_q)
    );
    tk_flag_cell #(.RST_VAL(1'b0)) u_af (
        .clk(clk), .rst_n(rst_n), .set_evt(alm_evt), .clr(status_wr), .flag(af_q)
    );

    assign irq_n = ~((pf_q & pie_q) | (af_q & aie_q));

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_W'(A_STATUS)) begin
            rd_mux[ST_OSF] = osf_q;
            rd_mux[ST_UIP] = uip;
            rd_mux[ST_PF]  = pf_q;
            rd_mux[ST_AF]  = af_q;
        end else if (addr == ADDR_W'(A_CTRL)) begin
            rd_mux[1:0] = {pie_q, aie_q};
        end else if (addr == ADDR_W'(A_RATE)) begin
            rd_mux[SEL_W-1:0] = sel_q;
        end else begin
            for (int b = 0; b < ALM_BYTES; b++)
                if (addr == ADDR_W'(A_ALM + b)) rd_mux = alarm_q[b*8 +: 8];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end
endmodule

// File: rtl/tk_status_irq_chk.sv
module tk_status_irq_chk #(
    parameter int UIP_CYC = 12000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       osc_run,
    input logic       status_wr,
    input logic       per_evt,
    input logic       osf_q,
    input logic       pf_q,
    input logic       af_q,
    input logic       pie_q,
    input logic       aie_q,
    input logic       uip,
    input logic       upd_fire,
    input logic       irq_n,
    input logic       rd_en,
    input logic [3:0] addr,
    input logic [7:0] rdata
);
    int unsigned uip_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   uip_run <= 0;
        else if (uip) uip_run <= uip_run + 1;
        else          uip_run <= 0;
    end

    a_r2_osf_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_run |=> osf_q);

    a_r3_pf_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && !per_evt) |=> !pf_q);

    a_r3_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (status_wr && per_evt) |=> pf_q);

    a_r6_pf_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_q && !status_wr) |=> pf_q);

    a_r8_irq_cause: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_n |-> ((pf_q && pie_q) || (af_q && aie_q)));

    a_r4_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == 4'd0) |=> (rdata[5:2] == 4'b0000));

    a_r9_fire_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |-> $fell(uip));

    a_r9_full_window: assert property (@(posedge clk) disable iff (!rst_n)
        upd_fire |-> (uip_run == UIP_CYC));
endmodule

bind tk_status_irq tk_status_irq_chk #(.UIP_CYC(UIP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .osc_run(osc_run), .status_wr(status_wr),
    .per_evt(per_evt), .osf_q(osf_q), .pf_q(pf_q), .af_q(af_q),
    .pie_q(pie_q), .aie_q(aie_q), .uip(uip), .upd_fire(upd_fire),
    .irq_n(irq_n), .rd_en(rd_en), .addr(addr), .rdata(rdata)
);

// File: tb/test_tk_status_irq.sv
module test_tk_status_irq;
    localparam int CLK_KHZ = 500;
    localparam int UIP_CYC = (CLK_KHZ * 60) / 1000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] addr = '0;
    logic [7:0] wdata = '0;
    logic       wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0] rdata;
    logic       osc_run = 1'b1, step_req = 1'b0;
    logic [6:0] rate_taps = '0;
    logic [31:0] sec_count = '0;
    logic       upd_fire, irq_n;

    int errors = 0, checks = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    tk_status_irq #(.CLK_KHZ(CLK_KHZ)) i_tk_status_irq (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .wr_en(wr_en),
        .rd_en(rd_en), .rdata(rdata), .osc_run(osc_run), .step_req(step_req),
        .rate_taps(rate_taps), .sec_count(sec_count), .upd_fire(upd_fire),
        .irq_n(irq_n)
    );

    task automatic check(string req, int act, int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input int d);
        @(negedge clk);
        addr = 4'(a); wdata = 8'(d); wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int d);
        @(negedge clk);
        addr = 4'(a); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = int'(rdata);
    endtask

    task automatic t_reset();
        int d;
        rd(0, d); check("R1 status", d, 8'h80);
        rd(1, d); check("R1 ctrl", d, 0);
        rd(2, d); check("R1 rate", d, 0);
        check("R1 irq_n", int'(irq_n), 1);
    endtask

    task automatic t_osc();
        int d;
        wr(0, 0);
        rd(0, d); check("R3 osf cleared", d, 0);
        @(negedge clk); osc_run = 1'b0;
        @(negedge clk); osc_run = 1'b1;
        rd(0, d); check("R2 osf set after stop", d, 8'h80);
        // write while oscillator is stopped: the event wins
        @(negedge clk); osc_run = 1'b0;
        wr(0, 8'hFF);
        osc_run = 1'b1;
        rd(0, d); check("R3 event wins over clear", d, 8'h80);
        wr(0, 0);
    endtask

    task automatic t_periodic();
        int d;
        wr(2, 0);
        @(negedge clk); rate_taps = 7'h7F;
        @(negedge clk); rate_taps = 7'h00;
        rd(0, d); check("R5 select 0 disables", d, 0);
        wr(2, 3);
        @(negedge clk); rate_taps[1] = 1'b1;
        @(negedge clk); rate_taps[1] = 1'b0;
        rd(0, d); check("R5 wrong tap ignored", d, 0);
        @(negedge clk); rate_taps[2] = 1'b1;
        @(negedge clk); rate_taps[2] = 1'b0;
        rd(0, d); check("R5 selected tap sets pf", d, 8'h02);
        @(negedge clk); rate_taps[2] = 1'b1;
        @(negedge clk); rate_taps[2] = 1'b0;
        rd(0, d); check("R6 pf stays set", d, 8'h02);
        wr(0, 0);
        rd(0, d); check("R3 pf cleared", d, 0);
        // edge on the same cycle as a status write
        @(negedge clk);
        addr = 4'd0; wr_en = 1'b1; rate_taps[2] = 1'b1;
        @(negedge clk); wr_en = 1'b0; rate_taps[2] = 1'b0;
        rd(0, d); check("R3 pf event wins", d, 8'h02);
        wr(0, 0);
    endtask

    task automatic t_alarm();
        int d;
        wr(4, 8'h34); wr(5, 8'h12); wr(6, 0); wr(7, 0);
        rd(5, d); check("R11 alarm byte readback", d, 8'h12);
        @(negedge clk); sec_count = 32'h1233;
        rd(0, d); check("R7 no match yet", d, 0);
        @(negedge clk); sec_count = 32'h1234;
        rd(0, d); check("R7 match sets af", d, 8'h01);
        wr(0, 0);
        repeat (3) @(negedge clk);
        rd(0, d); check("R7 held match does not reset af", d, 0);
    endtask

    task automatic t_irq();
        int d;
        wr(1, 8'h02);
        wr(2, 1);
        @(negedge clk); rate_taps[0] = 1'b1;
        @(negedge clk); rate_taps[0] = 1'b0;
        check("R8 irq on pf with enable", int'(irq_n), 0);
        wr(1, 8'h01);
        check("R8 irq released by disable", int'(irq_n), 1);
        wr(0, 0);
        @(negedge clk); sec_count = 32'h0;
        @(negedge clk); sec_count = 32'h1234;
        @(negedge clk);
        check("R8 irq on af with enable", int'(irq_n), 0);
        wr(0, 0);
        check("R8 irq released by clear", int'(irq_n), 1);
        wr(1, 0); wr(2, 0);
    endtask

    task automatic t_update();
        int d, n;
        @(negedge clk); step_req = 1'b1;
        n = 0;
        forever begin
            @(negedge clk); step_req = 1'b0; n++;
            if (upd_fire || n > 4 * UIP_CYC) break;
        end
        check("R9 fire delay", n, UIP_CYC + 1);
        @(negedge clk);
        check("R9 one-cycle pulse", int'(upd_fire), 0);
        @(negedge clk); step_req = 1'b1;
        @(negedge clk); step_req = 1'b0;
        rd(0, d); check("R9 uip visible", d, 8'h40);
        wr(0, 8'hFF);
        rd(0, d); check("R4 write leaves uip", d, 8'h40);
        rd(3, d); check("R11 unmapped reads 0", d, 0);
        while (!upd_fire) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic t_pending();
        int n, first, second;
        n = 0; first = -1; second = -1;
        @(negedge clk); step_req = 1'b1;
        @(negedge clk); step_req = 1'b0;
        repeat (3) @(negedge clk);
        step_req = 1'b1;
        @(negedge clk); step_req = 1'b0;
        for (int i = 0; i < 3 * UIP_CYC; i++) begin
            @(negedge clk);
            if (upd_fire) begin
                if (first < 0) first = i; else if (second < 0) second = i;
            end
        end
        check("R10 queued request served", int'(second >= 0), 1);
        check("R10 gap between updates", second - first, UIP_CYC + 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_osc();
        t_periodic();
        t_alarm();
        t_irq();
        t_update();
        t_pending();
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule